// File: doc/BRIEF.md
# Four-Lane PAM-5 Symbol Sign Scrambler

This block randomises the polarity of the four quinary symbols a gigabit copper transmitter sends in each symbol period, one symbol per twisted pair. A 33-bit side-stream shift register supplies the randomness. Its feedback polynomial depends on the link role: the master uses taps 13 and 33, and the slave uses taps 20 and 33. Four fixed register bits give one sign bit per lane. Each lane then either passes its symbol through or sends its negation, so every output is still a legal five-level value.

The block sits between the bit-to-symbol mapper and the transmit PMA. Each input symbol is a signed 3-bit value between -2 and +2. The mapper raises a strobe in every cycle that carries a new quartet of symbols. The role select is captured only while reset is held, so the polynomial stays fixed until the next reset.

Top module: `pam5_sign_scrambler`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and all four output symbols are 0. Reset loads the shift register with the nonzero seed 33'h1ABCDE123.
- R2: In master role (`role_sel` = 0 at reset), each advance shifts the register left by one place. The new bit 0 is bit 12 XOR bit 32, which implements 1 + x^13 + x^33.
- R3: In slave role (`role_sel` = 1 at reset), the new bit 0 is bit 19 XOR bit 32, which implements 1 + x^20 + x^33.
- R4: The sign bits of lanes A, B, C and D are bits 0, 8, 16 and 24 of the register state held before the advance. A sign bit of 1 means the symbol is negated.
- R5: When `in_valid` is high, each output symbol equals its input symbol times +1 or -1 according to its sign bit. The result appears one clock later, with `out_valid` high for that one cycle.
- R6: The register advances exactly once per cycle in which `in_valid` is high, and holds otherwise. While `in_valid` is low, the output symbols keep their last values and `out_valid` is 0.
- R7: A zero input symbol always produces zero, and every output stays within -2..+2. Symbols are two's complement: +2=010, +1=001, 0=000, -1=111, -2=110.
- R8: A change of `role_sel` while reset is low has no effect on the sign sequence.
- R9: The register never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous reset, active high; `role_sel` is sampled while it is high |
| role_sel | input | 1 | 0 selects the master polynomial, 1 the slave polynomial |
| in_valid | input | 1 | A new symbol quartet is present this cycle |
| sym_a_in | input | 3 | Lane A input symbol, signed |
| sym_b_in | input | 3 | Lane B input symbol, signed |
| sym_c_in | input | 3 | Lane C input symbol, signed |
| sym_d_in | input | 3 | Lane D input symbol, signed |
| out_valid | output | 1 | Registered copy of `in_valid` |
| sym_a_out | output | 3 | Lane A scrambled symbol, signed |
| sym_b_out | output | 3 | Lane B scrambled symbol, signed |
| sym_c_out | output | 3 | Lane C scrambled symbol, signed |
| sym_d_out | output | 3 | Lane D scrambled symbol, signed |

## Verification
A quartet presented in one cycle is due at the outputs one clock edge later, with `out_valid` high. Register advances in that same edge affect only the next quartet's signs. The bench drives each quartet on a falling edge and checks the matching result on the following falling edge, half a period after the capturing edge. It keeps its own model register, which it steps only in cycles where it drove the strobe. Idle cycles are checked at the same point for held symbols and a low `out_valid`. The reset-state check is read while reset is still high, and again on the falling edge after reset is released, before any strobe has been applied.

// File: rtl/pam5_sign_pkg.sv
package pam5_sign_pkg;
   localparam int unsigned LANES   = 4;
   localparam int unsigned SYM_W   = 3;
   localparam int unsigned LFSR_W  = 33;

   typedef logic signed [SYM_W-1:0] pam5_t;

   typedef enum logic {
      ROLE_MASTER = 1'b0,
      ROLE_SLAVE  = 1'b1
   } role_e;

   localparam pam5_t PAM5_MAX = pam5_t'(2);
   localparam pam5_t PAM5_MIN = pam5_t'(-2);

   function automatic logic in_pam5_range(input pam5_t v);
      return (v >= PAM5_MIN) && (v <= PAM5_MAX);
   endfunction
endpackage

// File: rtl/pam5_sign_lfsr.sv
module pam5_sign_lfsr #(
   parameter int unsigned W          = 33,
   parameter logic [W-1:0] SEED      = 33'h1ABCDE123,
   parameter int unsigned POLY_M     = 13,
   parameter int unsigned POLY_S     = 20,
   parameter int unsigned NSIGN      = 4,
   parameter int unsigned SIGN_TAP [NSIGN] = '{0, 8, 16, 24}
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             role_in,
   input  logic             adv,
   output logic [NSIGN-1:0] sign_o
);
   localparam int unsigned TOP = W - 1;
   localparam bit SAME_POLY = (POLY_M == POLY_S);

   if (SEED == '0) begin : g_bad_seed
      $error("pam5_sign_lfsr: seed must be nonzero");
   end
   if (POLY_M < 1 || POLY_M >= W || POLY_S < 1 || POLY_S >= W) begin : g_bad_poly
      $error("pam5_sign_lfsr: polynomial tap outside register");
   end
   for (genvar i = 0; i < NSIGN; i++) begin : g_tap_chk
      if (SIGN_TAP[i] >= W) begin : g_range
         $error("pam5_sign_lfsr: sign tap outside register");
      end
      for (genvar j = i + 1; j < NSIGN; j++) begin : g_dup
         if (SIGN_TAP[i] == SIGN_TAP[j]) begin : g_same
            $error("pam5_sign_lfsr: sign taps must be distinct");
         end
      end
   end

   logic [W-1:0] state;
   logic         role_q;
   logic         fb;

   if (SAME_POLY) begin : g_one_poly
      assign fb = state[POLY_M-1] ^ state[TOP];
   end else begin : g_two_poly
      logic fb_m, fb_s;
      assign fb_m = state[POLY_M-1] ^ state[TOP];
      assign fb_s = state[POLY_S-1] ^ state[TOP];
      assign fb   = role_q ? fb_s : fb_m;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= SEED;
         role_q <= role_in;
      end else if (adv) begin
         state  <= {state[W-2:0], fb};
      end
   end

   for (genvar i = 0; i < NSIGN; i++) begin : g_sign
      assign sign_o[i] = state[SIGN_TAP[i]];
   end

   assert_state_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
      state != '0);
   assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(state));
   assert_shift_when_strobed_R6: assert property (@(posedge clk) disable iff (rst)
      adv |=> state[W-1:1] == $past(state[W-2:0]));
   assert_role_frozen_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(role_q));
endmodule

// File: rtl/pam5_sign_lane.sv
module pam5_sign_lane
   import pam5_sign_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  vld,
   input  logic  flip,
   input  pam5_t sym_in,
   output pam5_t sym_out
);
   pam5_t sym_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sym_q <= '0;
      end else if (vld) begin
         sym_q <= flip ? pam5_t'(-sym_in) : sym_in;
      end
   end

   assign sym_out = sym_q;

   assert_magnitude_kept_R5: assert property (@(posedge clk) disable iff (rst)
      vld |=> (sym_out == $past(sym_in)) || (sym_out == pam5_t'(-$past(sym_in))));
   assert_zero_passes_R7: assert property (@(posedge clk) disable iff (rst)
      (vld && sym_in == '0) |=> sym_out == '0);
   assert_in_range_R7: assert property (@(posedge clk) disable iff (rst)
      (vld && in_pam5_range(sym_in)) |=> in_pam5_range(sym_out));
   assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
      !vld |=> $stable(sym_out));
endmodule

// File: rtl/pam5_sign_scrambler.sv
module pam5_sign_scrambler
   import pam5_sign_pkg::*;
#(
   parameter logic [LFSR_W-1:0] SEED = 33'h1ABCDE123,
   parameter int unsigned POLY_M     = 13,
   parameter int unsigned POLY_S     = 20,
   parameter int unsigned SIGN_TAP [LANES] = '{0, 8, 16, 24}
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              role_sel,
   input  logic              in_valid,
   input  logic signed [2:0] sym_a_in,
   input  logic signed [2:0] sym_b_in,
   input  logic signed [2:0] sym_c_in,
   input  logic signed [2:0] sym_d_in,
   output logic              out_valid,
   output logic signed [2:0] sym_a_out,
   output logic signed [2:0] sym_b_out,
   output logic signed [2:0] sym_c_out,
   output logic signed [2:0] sym_d_out
);
   logic [LANES-1:0] sign;
   pam5_t            lane_in  [LANES];
   pam5_t            lane_out [LANES];
   logic             vld_q;

   assign lane_in[0] = sym_a_in;
   assign lane_in[1] = sym_b_in;
   assign lane_in[2] = sym_c_in;
   assign lane_in[3] = sym_d_in;

   pam5_sign_lfsr #(
      .W        (LFSR_W),
      .SEED     (SEED),
      .POLY_M   (POLY_M),
      .POLY_S   (POLY_S),
      .NSIGN    (LANES),
      .SIGN_TAP (SIGN_TAP)
   ) u_lfsr (
      .clk     (clk),
      .rst     (rst),
      .role_in (role_sel),
      .adv     (in_valid),
      .sign_o  (sign)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      pam5_sign_lane u_lane (
         .clk     (clk),
         .rst     (rst),
         .vld     (in_valid),
         .flip    (sign[i]),
         .sym_in  (lane_in[i]),
         .sym_out (lane_out[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= in_valid;
   end

   assign out_valid = vld_q;
   assign sym_a_out = lane_out[0];
   assign sym_b_out = lane_out[1];
   assign sym_c_out = lane_out[2];
   assign sym_d_out = lane_out[3];

   assert_valid_follows_R5: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   assert_valid_drops_R6: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> !out_valid && sym_a_out == '0 && sym_d_out == '0);
endmodule

// File: tb/sim_pam5_sign_scrambler.sv
module sim_pam5_sign_scrambler;
   localparam time PERIOD = 10ns;
   localparam logic [32:0] SEED = 33'h1ABCDE123;
   localparam logic [2:0] P2 = 3'b010, P1 = 3'b001, Z0 = 3'b000,
                          M1 = 3'b111, M2 = 3'b110;
   localparam int NV = 12;
   // {valid, A, B, C, D}
   localparam logic [12:0] VEC [NV] = '{
      {1'b1, P1, P1, P1, P1}, {1'b1, P2, M2, P1, M1},
      {1'b0, P2, P2, P2, P2}, {1'b1, Z0, P2, Z0, M2},
      {1'b1, M1, M1, M2, M2}, {1'b1, P2, P1, Z0, M1},
      {1'b0, M2, M1, Z0, P1}, {1'b0, Z0, Z0, P1, P1},
      {1'b1, M2, Z0, P2, P1}, {1'b1, P1, M1, P1, M1},
      {1'b1, Z0, Z0, Z0, Z0}, {1'b1, M2, P2, M2, P2}
   };

   logic clk = 1'b0, rst = 1'b1, role_sel = 1'b0, in_valid = 1'b0;
   logic signed [2:0] a_i = '0, b_i = '0, c_i = '0, d_i = '0;
   logic out_valid;
   logic signed [2:0] a_o, b_o, c_o, d_o;

   int checks = 0, errors = 0;
   logic [32:0] ms;
   logic        mrole;
   logic signed [2:0] ea = '0, eb = '0, ec = '0, ed = '0;

   always #(PERIOD/2) clk = ~clk;

   pam5_sign_scrambler u0 (
      .clk(clk), .rst(rst), .role_sel(role_sel), .in_valid(in_valid),
      .sym_a_in(a_i), .sym_b_in(b_i), .sym_c_in(c_i), .sym_d_in(d_i),
      .out_valid(out_valid),
      .sym_a_out(a_o), .sym_b_out(b_o), .sym_c_out(c_o), .sym_d_out(d_o)
   );

   function automatic logic [32:0] step(input logic [32:0] s, input logic r);
      logic fbit = r ? (s[19] ^ s[32]) : (s[12] ^ s[32]);
      return {s[31:0], fbit};
   endfunction

   function automatic logic signed [2:0] apply(input logic f, input logic signed [2:0] v);
      return f ? -v : v;
   endfunction

   function automatic logic rng(input logic signed [2:0] v);
      return v >= -3'sd2 && v <= 3'sd2;
   endfunction

   task automatic check(input string tag, input logic ok, input string got, input string exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %s expected %s", tag, got, exp);
      end
   endtask

   task automatic do_reset(input logic r);
      @(negedge clk);
      rst = 1'b1; role_sel = r; in_valid = 1'b0;
      @(negedge clk); @(negedge clk);
      check("R1 during reset", out_valid == 1'b0 && {a_o, b_o, c_o, d_o} == '0,
            $sformatf("%b %h", out_valid, {a_o, b_o, c_o, d_o}), "0 000");
      rst = 1'b0;
      ms = SEED; mrole = r;
      ea = '0; eb = '0; ec = '0; ed = '0;
      @(negedge clk);
      check("R1 after reset", out_valid == 1'b0 && {a_o, b_o, c_o, d_o} == '0,
            $sformatf("%b %h", out_valid, {a_o, b_o, c_o, d_o}), "0 000");
   endtask

   // one cycle: drive at negedge, check at the next negedge
   task automatic cycle(input logic [12:0] v, input string tag);
      in_valid = v[12];
      a_i = v[11:9]; b_i = v[8:6]; c_i = v[5:3]; d_i = v[2:0];
      if (v[12]) begin
         ea = apply(ms[0], a_i);  eb = apply(ms[8], b_i);
         ec = apply(ms[16], c_i); ed = apply(ms[24], d_i);
         ms = step(ms, mrole);
      end
      @(negedge clk);
      check(tag, out_valid == v[12] && a_o == ea && b_o == eb && c_o == ec && d_o == ed,
            $sformatf("v=%b %0d %0d %0d %0d", out_valid, a_o, b_o, c_o, d_o),
            $sformatf("v=%b %0d %0d %0d %0d", v[12], ea, eb, ec, ed));
      check("R7 range", rng(a_o) && rng(b_o) && rng(c_o) && rng(d_o),
            $sformatf("%0d %0d %0d %0d", a_o, b_o, c_o, d_o), "within -2..2");
   endtask

   initial begin
      // master role: table walk (R2 R4 R5 R6)
      do_reset(1'b0);
      for (int i = 0; i < NV; i++) cycle(VEC[i], "R2 R4 R5 R6 master table");

      // R4: seed bits 0,8,16,24 are all 1, so +1 on every lane must come out as -1
      do_reset(1'b0);
      cycle({1'b1, P1, P1, P1, P1}, "R4 seed signs");
      check("R4 direct", {a_o, b_o, c_o, d_o} == {M1, M1, M1, M1},
            $sformatf("%h", {a_o, b_o, c_o, d_o}), "all -1");

      // R6: idle stretch does not advance the sequence
      for (int i = 0; i < 5; i++) cycle({1'b0, P2, P2, P2, P2}, "R6 idle hold");
      for (int i = 0; i < 40; i++) cycle({1'b1, P2, M1, P1, M2}, "R2 R6 long run");

      // R7: zero symbols with both sign values
      for (int i = 0; i < 8; i++) cycle({1'b1, Z0, Z0, Z0, Z0}, "R7 zero passes");

      // R8: role change without reset is ignored
      role_sel = 1'b1;
      for (int i = 0; i < NV; i++) cycle(VEC[i], "R8 role change ignored");
      for (int i = 0; i < 40; i++) cycle({1'b1, P1, P1, P1, P1}, "R8 R9 master continues");

      // R3: slave role
      do_reset(1'b1);
      role_sel = 1'b0;
      for (int i = 0; i < NV; i++) cycle(VEC[i], "R3 slave table");
      for (int i = 0; i < 60; i++) cycle({1'b1, M2, P1, M1, P2}, "R3 R9 slave run");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule